// File: doc/BRIEF.md
# Console serial port

This block is a console serial port that a processor reaches as four 16-bit word registers in its I/O page. Two registers serve the receive side, one for status and one for the received character. The other two serve the transmit side, one for status and one for the outgoing character. The line settings are fixed in hardware: 8 data bits, no parity and 1 stop bit. A built-in monitor program can therefore poll and write the port with no set-up writes after reset.

Software sending a character polls bit 7 of the transmit status register until it reads 1. It then writes the character into the low byte of the transmit data register. Software receiving a character polls bit 7 of the receive status register. It then reads the receive data register, and that read frees the slot. An external tick input sets the bit rate: each bit on the line lasts 16 ticks. Register reads are combinational on `rdata` while `rd` is high. Register side effects take place at the clock edge that samples `rd` or `wr`.

Top module: `console_port`

## Requirements
- R1: The four registers sit at word addresses BASE+0 (receive status), BASE+2 (receive data), BASE+4 (transmit status) and BASE+6 (transmit data), with BASE = 177560 octal. Any other address reads as 0, and a write to it has no effect.
- R2: After reset, transmit status bit 7 reads 1, receive status bit 7 reads 0, the receive data register reads 0, and `txd` is high.
- R3: Transmit status bit 7 reads 1 while the transmitter is idle. A write to transmit data makes it read 0 from the next cycle until the frame's stop bit has ended.
- R4: A transmitted frame is one low start bit, then wdata[7:0] least significant bit first, then one high stop bit, each bit lasting 16 ticks. wdata[15:8] is not sent.
- R5: A write to transmit data while transmit status bit 7 reads 0 is ignored, and no extra frame is sent.
- R6: The receiver samples `rxd` at mid-bit. After a frame with a high stop bit, receive data bits 7:0 hold the character and receive status bit 7 reads 1.
- R7: A read of receive data clears receive status bit 7 and the overrun bit from the next cycle, and the character stays readable.
- R8: A character that arrives while receive status bit 7 is 1 replaces the old one and sets bit 12 of receive data (overrun).
- R9: Unused register bits read 0, and writes to the two status registers change nothing.
- R10: A low pulse on `rxd` shorter than half a bit is not taken as a start bit, and no character is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Baud tick, 16 per bit time |
| addr | input | 16 | Bus word address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rd is high |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line |

## Verification
Register reads are due in the same cycle as `rd`, so the bench samples `rdata` just after driving the strobe, before the clock edge that applies a read's side effect. Transmit ready falls one cycle after the write edge, and the bench reads it at the next falling clock edge. The transmit monitor times each frame from the start-bit falling edge and samples every bit at mid-bit, 64 clocks apart, which leaves room for the tick phase. A received character is due a few cycles after the middle of its stop bit, so the bench reads status only after driving the whole stop bit.

// File: rtl/conport_pkg.sv
package conport_pkg;
    localparam int unsigned REG_W   = 16;
    localparam int unsigned RDY_BIT = 7;
    localparam int unsigned OVR_BIT = 12;

    typedef enum logic [1:0] {
        SEL_RX_STAT = 2'd0,
        SEL_RX_DATA = 2'd1,
        SEL_TX_STAT = 2'd2,
        SEL_TX_DATA = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/conport_tx.sv
module conport_tx #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              ready,
    output logic              txd
);
    localparam int unsigned FRAME_W = DATA_W + 2;
    localparam int unsigned TW      = $clog2(OVS);
    localparam int unsigned BW      = $clog2(FRAME_W);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] shreg;
        logic [BW-1:0]      bitcnt;
        logic [TW-1:0]      tickcnt;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (load) begin
                st_d.busy    = 1'b1;
                st_d.shreg   = {1'b1, data, 1'b0};
                st_d.bitcnt  = '0;
                st_d.tickcnt = '0;
            end
        end else if (tick) begin
            if (st_q.tickcnt == TW'(OVS - 1)) begin
                st_d.tickcnt = '0;
                st_d.shreg   = {1'b1, st_q.shreg[FRAME_W-1:1]};
                if (st_q.bitcnt == BW'(FRAME_W - 1)) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.bitcnt = st_q.bitcnt + 1'b1;
                end
            end else begin
                st_d.tickcnt = st_q.tickcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy    <= 1'b0;
            st_q.shreg   <= '1;
            st_q.bitcnt  <= '0;
            st_q.tickcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = !st_q.busy;
    assign txd   = st_q.shreg[0];
endmodule

// File: rtl/conport_rx.sv
module conport_rx
    import conport_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    localparam int unsigned TW   = $clog2(OVS);
    localparam int unsigned BW   = $clog2(DATA_W);
    localparam int unsigned HALF = OVS / 2;

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         state;
        logic [TW-1:0]     tickcnt;
        logic [BW-1:0]     bitcnt;
        logic [DATA_W-1:0] shreg;
        logic              valid;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   line;

    assign line = st_q.sync[1];

    always_comb begin
        st_d       = st_q;
        st_d.sync  = {st_q.sync[0], rxd};
        st_d.valid = 1'b0;
        if (tick) begin
            unique case (st_q.state)
                RX_IDLE: begin
                    if (!line) begin
                        st_d.state   = RX_START;
                        st_d.tickcnt = '0;
                    end
                end
                RX_START: begin
                    if (st_q.tickcnt == TW'(HALF - 1)) begin
                        st_d.tickcnt = '0;
                        st_d.bitcnt  = '0;
                        st_d.state   = line ? RX_IDLE : RX_DATA;
                    end else begin
                        st_d.tickcnt = st_q.tickcnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (st_q.tickcnt == TW'(OVS - 1)) begin
                        st_d.tickcnt = '0;
                        st_d.shreg   = {line, st_q.shreg[DATA_W-1:1]};
                        if (st_q.bitcnt == BW'(DATA_W - 1)) begin
                            st_d.state = RX_STOP;
                        end else begin
                            st_d.bitcnt = st_q.bitcnt + 1'b1;
                        end
                    end else begin
                        st_d.tickcnt = st_q.tickcnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (st_q.tickcnt == TW'(OVS - 1)) begin
                        st_d.tickcnt = '0;
                        st_d.state   = RX_IDLE;
                        st_d.valid   = line;
                    end else begin
                        st_d.tickcnt = st_q.tickcnt + 1'b1;
                    end
                end
                default: st_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync    <= 2'b11;
            st_q.state   <= RX_IDLE;
            st_q.tickcnt <= '0;
            st_q.bitcnt  <= '0;
            st_q.shreg   <= '0;
            st_q.valid   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign data  = st_q.shreg;
endmodule

// File: rtl/console_port.sv
module console_port
    import conport_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'o177560,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned OVS       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              txd,
    input  logic              rxd
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    typedef struct packed {
        logic              rx_done;
        logic              overrun;
        logic [DATA_W-1:0] rx_char;
    } port_st_t;

    port_st_t          st_d, st_q;
    logic              hit;
    reg_sel_e          sel;
    logic              tx_ready;
    logic              tx_load;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_data;
    logic              rd_clr;

    assign hit     = (addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]) && !addr[0];
    assign sel     = reg_sel_e'(addr[2:1]);
    assign tx_load = wr && hit && (sel == SEL_TX_DATA) && tx_ready;
    assign rd_clr  = rd && hit && (sel == SEL_RX_DATA);

    conport_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (tx_load),
        .data  (wdata[DATA_W-1:0]),
        .ready (tx_ready),
        .txd   (txd)
    );

    conport_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rxd   (rxd),
        .valid (rx_valid),
        .data  (rx_data)
    );

    always_comb begin
        st_d = st_q;
        if (rd_clr) begin
            st_d.rx_done = 1'b0;
            st_d.overrun = 1'b0;
        end
        if (rx_valid) begin
            st_d.overrun = st_q.rx_done && !rd_clr;
            st_d.rx_done = 1'b1;
            st_d.rx_char = rx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rx_done <= 1'b0;
            st_q.overrun <= 1'b0;
            st_q.rx_char <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd && hit) begin
            unique case (sel)
                SEL_RX_STAT: rdata[RDY_BIT] = st_q.rx_done;
                SEL_RX_DATA: begin
                    rdata[DATA_W-1:0] = st_q.rx_char;
                    rdata[OVR_BIT]    = st_q.overrun;
                end
                SEL_TX_STAT: rdata[RDY_BIT] = tx_ready;
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/conport_chk.sv
module conport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_ready,
    input logic        tx_load,
    input logic        txd,
    input logic        rx_valid,
    input logic        rd_clr,
    input logic        rx_done,
    input logic        overrun,
    input logic [15:0] rdata
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd); // R2

    AST_LOAD_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_ready); // R3

    AST_VALID_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_done); // R6

    AST_READ_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !rx_valid) |=> (!rx_done && !overrun)); // R7

    AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_done && !rd_clr) |=> overrun); // R8

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[15:13] == 3'b0) && (rdata[11:8] == 4'b0)); // R9
endmodule

bind console_port conport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_ready (tx_ready),
    .tx_load  (tx_load),
    .txd      (txd),
    .rx_valid (rx_valid),
    .rd_clr   (rd_clr),
    .rx_done  (st_q.rx_done),
    .overrun  (st_q.overrun),
    .rdata    (rdata)
);

// File: tb/test_console_port.sv
module test_console_port;
    localparam int BITCLK = 64;
    localparam logic [15:0] A_RST = 16'o177560;
    localparam logic [15:0] A_RDT = 16'o177562;
    localparam logic [15:0] A_TST = 16'o177564;
    localparam logic [15:0] A_TDT = 16'o177566;
    localparam logic [15:0] A_OUT = 16'o177570;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        txd;
    logic        rxd = 1'b1;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [7:0]  exp_q[$];
    logic [1:0]  tdiv = '0;

    console_port i_console_port (
        .clk, .rst_n, .tick, .addr, .rd, .wr, .wdata, .rdata, .txd, .rxd
    );

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    // driver: a write that should launch a frame pushes the expected byte
    task automatic send_char(input logic [15:0] d);
        exp_q.push_back(d[7:0]);
        bus_write(A_TDT, d);
    endtask

    task automatic drive_serial(input logic [7:0] b);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BITCLK) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (BITCLK + 8) @(negedge clk);
    endtask

    task automatic wait_tx_idle();
        logic [15:0] v;
        for (int k = 0; k < 40; k++) begin
            bus_read(A_TST, v);
            if (v[7]) break;
            repeat (50) @(negedge clk);
        end
        repeat (BITCLK) @(negedge clk);
    endtask

    // monitor: decode each frame on txd and compare with the queue (R4)
    initial begin
        logic [7:0] got;
        logic [7:0] exp;
        wait (rst_n);
        forever begin
            @(negedge txd);
            repeat (BITCLK / 2) @(negedge clk);
            check("R4 start bit", {15'b0, txd}, 16'h0000);
            for (int i = 0; i < 8; i++) begin
                repeat (BITCLK) @(negedge clk);
                got[i] = txd;
            end
            repeat (BITCLK) @(negedge clk);
            check("R4 stop bit", {15'b0, txd}, 16'h0001);
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R5 unexpected frame: actual %h expected none", got);
            end else begin
                exp = exp_q.pop_front();
                check("R4 frame data", {8'b0, got}, {8'b0, exp});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        bus_read(A_RST, v); check("R2 rx status after reset", v, 16'h0000);
        bus_read(A_TST, v); check("R2 tx status after reset", v, 16'h0080);
        bus_read(A_RDT, v); check("R2 rx data after reset", v, 16'h0000);
        check("R2 txd idle", {15'b0, txd}, 16'h0001);

        // transmit, high byte dropped
        send_char(16'hAB42);
        bus_read(A_TST, v); check("R3 tx busy after write", v, 16'h0000);
        bus_write(A_TDT, 16'h0055); // R5: must be dropped
        repeat (200) @(negedge clk);
        bus_read(A_TST, v); check("R3 tx busy mid frame", v, 16'h0000);
        wait_tx_idle();
        bus_read(A_TST, v); check("R3 tx ready after frame", v, 16'h0080);

        send_char(16'h0081);
        wait_tx_idle();

        // status writes and out-of-range address
        bus_write(A_RST, 16'hFFFF);
        bus_write(A_TST, 16'hFFFF);
        bus_read(A_RST, v); check("R9 rx status write ignored", v, 16'h0000);
        bus_read(A_TST, v); check("R9 tx status write ignored", v, 16'h0080);
        bus_write(A_OUT, 16'h0033);
        bus_read(A_TST, v); check("R1 outside write no launch", v, 16'h0080);
        bus_read(A_OUT, v); check("R1 outside read zero", v, 16'h0000);
        repeat (BITCLK * 12) @(negedge clk);

        // receive
        drive_serial(8'hA5);
        bus_read(A_RST, v); check("R6 rx done", v, 16'h0080);
        bus_read(A_RDT, v); check("R6 rx char", v, 16'h00A5);
        bus_read(A_RST, v); check("R7 done cleared by read", v, 16'h0000);

        // overrun
        drive_serial(8'h3C);
        drive_serial(8'hC3);
        bus_read(A_RDT, v); check("R8 overrun and new char", v, 16'h10C3);
        bus_read(A_RST, v); check("R7 done cleared after overrun", v, 16'h0000);
        bus_read(A_RDT, v); check("R7 overrun cleared, char kept", v, 16'h00C3);

        // short glitch is no start bit
        @(negedge clk);
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK * 12) @(negedge clk);
        bus_read(A_RST, v); check("R10 glitch rejected", v, 16'h0000);

        wait_tx_idle();
        repeat (BITCLK * 2) @(negedge clk);
        check("R4 all frames seen", 16'(exp_q.size()), 16'h0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule